// File: doc/BRIEF.md
# Memory BIST Command Sequencer

This block steps an external DRAM through a built-in self-test. After a start pulse it walks an address window upward, one command per address. It presents each command on a valid/type/address strobe and holds it there until the DRAM scheduler reports that the timing for the command is met. A test can be a write pass alone, or a write pass followed by a read pass. In the read pass the block can also write straight back to each address right after reading it. A fourth mode runs only that read-and-write-back pass.

Before each pass that uses pseudo-random data, the block spends five cycles filling five pattern registers. Each word is one CRC32 shift step of the word before it, and the chain starts from the captured seed. With fixed data, all five registers take the seed itself. Read data returns on a separate port and is compared with the pattern word that its address selects, taken as the address modulo five. Any mismatch sets a sticky error flag.

The controller is one state machine. Its states are ST_IDLE, ST_WSEED, ST_WADDR, ST_WCMD, ST_WDRAIN, ST_WFIN, ST_RSTART, ST_RSEED, ST_RADDR, ST_RCMD, ST_RWBADDR, ST_RWBCMD, ST_RDRAIN and ST_RFIN. The transitions are:
- IDLE goes to RSTART in read-write-back-only mode. Otherwise it goes to WSEED with pseudo-random data and to WADDR with fixed data.
- WSEED goes to WADDR after its fifth cycle.
- WADDR always goes to WCMD.
- WCMD goes, on ready, to WADDR, or to WDRAIN when the address is the last one.
- WDRAIN goes to WFIN on ready.
- WFIN goes to IDLE in write-only mode and to RSTART otherwise.
- RSTART goes to RSEED with pseudo-random data and to RADDR otherwise.
- RSEED goes to RADDR after its fifth cycle.
- RADDR always goes to RCMD.
- RCMD goes, on ready, to RWBADDR in the write-back modes. Otherwise it goes to RADDR, or to RDRAIN when the address is the last one.
- RWBADDR always goes to RWBCMD.
- RWBCMD goes, on ready, to RADDR, or to RDRAIN when the address is the last one.
- RDRAIN goes to RFIN on ready.
- RFIN always goes to IDLE.

Top module: `mbist_seq`

## Requirements
- R1: After reset, cmd_vld_o, busy_o, done_o and err_o are 0.
- R2: A start is taken only in idle, and busy_o is 1 from the next cycle. At that start the block captures mode, data type, seed and both address bounds. Later changes to those inputs, and start pulses while busy, do not change the command stream.
- R3: The mode encoding sets the order of the passes. 0 is a write pass only. 1 is a write pass then a read pass. 2 is a write pass then a read pass with a write-back after every read. 3 is the read pass with write-back only.
- R4: Each pass issues commands to addr_lo_i, addr_lo_i+1, and so on up to addr_hi_i inclusive. When the two bounds are equal, a pass issues one command. cmd_wr_o is 1 for a write and 0 for a read. A write-back uses the address just read.
- R5: A command is accepted in a cycle where cmd_vld_o and sched_rdy_i are both 1. Until it is accepted, cmd_vld_o, cmd_addr_o and cmd_wr_o stay unchanged.
- R6: In the cycle after every accepted command, cmd_vld_o is 0, because the next address is being prepared.
- R7: With dtype_i=1, the seeding phase lasts five cycles and loads word k (k=0..4) with step^(k+1)(seed). One step is next = (w<<1) XOR (w[31] ? 32'h04C11DB7 : 0). A write pass then presents its first command 6 rising edges after the edge that accepts start. With dtype_i=0, all five words equal the seed and the first command comes 1 edge after that edge.
- R8: A read pass with dtype_i=1 reseeds from the captured seed, which costs five cycles. With the scheduler always ready, the first read appears 10 cycles after the last write was accepted, or 5 cycles with dtype_i=0. In mode 3 the first read appears 7 edges after the accepting edge with dtype_i=1.
- R9: After the last command of a pass is accepted, busy_o stays 1 until sched_rdy_i is seen high in the drain state. The block then spends one finishing cycle, and the pass ends after that.
- R10: done_o is a single-cycle pulse in the first idle cycle after a test ends. busy_o is 0 in that cycle.
- R11: When rd_vld_i=1 and rd_data_i differs from pattern word (rd_addr_i mod 5), err_o is 1 from the next cycle. The flag stays set until a start is accepted, which clears it.
- R12: pat_o carries pattern word k in bits [32k+31:32k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken in idle |
| mode_i | input | 2 | Test mode, encoded as in R3 |
| dtype_i | input | 1 | 1 = CRC pseudo-random patterns, 0 = seed as a fixed pattern |
| seed_i | input | 32 | Pattern seed |
| addr_lo_i | input | ADDR_W | First address of each pass |
| addr_hi_i | input | ADDR_W | Last address of each pass, inclusive |
| sched_rdy_i | input | 1 | Scheduler reports that command timing is met |
| rd_vld_i | input | 1 | Read data returned |
| rd_addr_i | input | ADDR_W | Address of the returned read data |
| rd_data_i | input | 32 | Returned read data |
| cmd_vld_o | output | 1 | Command presented |
| cmd_wr_o | output | 1 | 1 = write, 0 = read |
| cmd_addr_o | output | ADDR_W | Command address |
| pat_o | output | NUM_PAT*32 | Pattern registers, laid out as in R12 |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle pulse at the end of a test |
| err_o | output | 1 | Sticky compare error |

## Verification
The bench builds the block with its defaults: ADDR_W=8 and NUM_PAT=5. An 8-bit address reaches the top of the space (250 to 255) without wrapping. Five pattern words make address-modulo-five selection differ from plain low-bit selection, so a compare at address 7 picks word 2. Ready masks that stall commands, stall the drain state, or stay high give the hold, gap, drain and reseed-latency rules cycle-exact expected values.

// File: rtl/mbist_pkg.sv
`timescale 1ns/1ps
package mbist_pkg;

    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C11DB7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WSEED,
        ST_WADDR,
        ST_WCMD,
        ST_WDRAIN,
        ST_WFIN,
        ST_RSTART,
        ST_RSEED,
        ST_RADDR,
        ST_RCMD,
        ST_RWBADDR,
        ST_RWBCMD,
        ST_RDRAIN,
        ST_RFIN
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_WR_ONLY   = 2'd0,
        MODE_WR_RD     = 2'd1,
        MODE_WR_RDWB   = 2'd2,
        MODE_RDWB_ONLY = 2'd3
    } test_mode_e;

    // one CRC32 shift step of a data word
    function automatic logic [WORD_W-1:0] crc_step(input logic [WORD_W-1:0] w);
        return {w[WORD_W-2:0], 1'b0} ^ (w[WORD_W-1] ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/mbist_pat_gen.sv
`timescale 1ns/1ps
module mbist_pat_gen
    import mbist_pkg::*;
#(
    parameter int unsigned NUM_PAT = 5
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        fill_fixed_i,
    input  logic                        init_i,
    input  logic                        run_i,
    input  logic [WORD_W-1:0]           seed_i,
    output logic [NUM_PAT*WORD_W-1:0]   pat_o,
    output logic                        last_o
);

    localparam int unsigned CNT_W = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1;

    logic [WORD_W-1:0] lfsr_q;
    logic [WORD_W-1:0] lfsr_nxt;
    logic [CNT_W-1:0]  cnt_q;

    assign lfsr_nxt = crc_step(lfsr_q);
    assign last_o   = run_i && (cnt_q == CNT_W'(NUM_PAT - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lfsr_q <= '0;
            cnt_q  <= '0;
        end else if (init_i) begin
            lfsr_q <= seed_i;
            cnt_q  <= '0;
        end else if (run_i) begin
            lfsr_q <= lfsr_nxt;
            cnt_q  <= last_o ? '0 : cnt_q + 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_PAT; k++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                word_q <= '0;
            end else if (fill_fixed_i) begin
                word_q <= seed_i;
            end else if (run_i && (cnt_q == CNT_W'(k))) begin
                word_q <= lfsr_nxt;
            end
        end
        assign pat_o[k*WORD_W +: WORD_W] = word_q;
    end

    // R7: the seeding phase cannot end before every word is filled
    p_seed_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !last_o && !init_i) |=> run_i);

endmodule

// File: rtl/mbist_addr_gen.sv
`timescale 1ns/1ps
module mbist_addr_gen #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              restart_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [ADDR_W-1:0] hi_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    logic              first_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            first_q <= 1'b1;
            addr_q  <= '0;
        end else if (restart_i) begin
            first_q <= 1'b1;
        end else if (step_i) begin
            addr_q  <= first_q ? lo_i : addr_q + 1'b1;
            first_q <= 1'b0;
        end
    end

    assign addr_o = addr_q;
    assign last_o = !first_q && (addr_q == hi_i);

    // R4: the controller never steps beyond the inclusive upper bound
    p_no_step_past_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |-> !last_o);

endmodule

// File: rtl/mbist_cmp.sv
`timescale 1ns/1ps
module mbist_cmp
    import mbist_pkg::*;
#(
    parameter int unsigned NUM_PAT = 5,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      clr_i,
    input  logic                      chk_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [WORD_W-1:0]         data_i,
    input  logic [NUM_PAT*WORD_W-1:0] pat_i,
    output logic                      err_o
);

    localparam int unsigned IDX_W = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1;

    logic [WORD_W-1:0] pat_arr [NUM_PAT];
    logic [ADDR_W-1:0] sel;
    logic [IDX_W-1:0]  idx;
    logic              miss;
    logic              err_q;

    for (genvar k = 0; k < NUM_PAT; k++) begin : g_unpack
        assign pat_arr[k] = pat_i[k*WORD_W +: WORD_W];
    end

    assign sel  = addr_i % ADDR_W'(NUM_PAT);
    assign idx  = IDX_W'(sel);
    assign miss = chk_i && (data_i != pat_arr[idx]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_q <= 1'b0;
        end else if (clr_i) begin
            err_q <= 1'b0;
        end else if (miss) begin
            err_q <= 1'b1;
        end
    end

    assign err_o = err_q;

    // R11: once set, the flag holds until a start clears it
    p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o && !clr_i) |=> err_o);

endmodule

// File: rtl/mbist_seq.sv
`timescale 1ns/1ps
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_PAT = 5
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      start_i,
    input  logic [1:0]                mode_i,
    input  logic                      dtype_i,
    input  logic [WORD_W-1:0]         seed_i,
    input  logic [ADDR_W-1:0]         addr_lo_i,
    input  logic [ADDR_W-1:0]         addr_hi_i,
    input  logic                      sched_rdy_i,
    input  logic                      rd_vld_i,
    input  logic [ADDR_W-1:0]         rd_addr_i,
    input  logic [WORD_W-1:0]         rd_data_i,
    output logic                      cmd_vld_o,
    output logic                      cmd_wr_o,
    output logic [ADDR_W-1:0]         cmd_addr_o,
    output logic [NUM_PAT*WORD_W-1:0] pat_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      err_o
);

    seq_state_e        state_q, state_nxt;
    test_mode_e        mode_q;
    logic              dtype_q;
    logic [WORD_W-1:0] seed_q;
    logic [ADDR_W-1:0] lo_q, hi_q;
    logic              done_q;

    logic              start_acc;
    logic              pass_init;
    logic              seed_run;
    logic              seed_last;
    logic              addr_step;
    logic              addr_last;
    logic              fill_fixed;
    logic              wb_mode;
    logic [WORD_W-1:0] seed_src;

    assign start_acc  = start_i && (state_q == ST_IDLE);
    assign wb_mode    = (mode_q == MODE_WR_RDWB) || (mode_q == MODE_RDWB_ONLY);
    assign fill_fixed = start_acc && !dtype_i;
    assign seed_src   = (state_q == ST_IDLE) ? seed_i : seed_q;

    // captured test setup
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q  <= MODE_WR_ONLY;
            dtype_q <= 1'b0;
            seed_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (start_acc) begin
            mode_q  <= test_mode_e'(mode_i);
            dtype_q <= dtype_i;
            seed_q  <= seed_i;
            lo_q    <= addr_lo_i;
            hi_q    <= addr_hi_i;
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // end-of-test pulse, seen in the first idle cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_RFIN) ||
                      ((state_q == ST_WFIN) && (mode_q == MODE_WR_ONLY));
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (test_mode_e'(mode_i) == MODE_RDWB_ONLY) state_nxt = ST_RSTART;
                    else if (dtype_i)                           state_nxt = ST_WSEED;
                    else                                        state_nxt = ST_WADDR;
                end
            end
            ST_WSEED:   if (seed_last) state_nxt = ST_WADDR;
            ST_WADDR:   state_nxt = ST_WCMD;
            ST_WCMD: begin
                if (sched_rdy_i) state_nxt = addr_last ? ST_WDRAIN : ST_WADDR;
            end
            ST_WDRAIN:  if (sched_rdy_i) state_nxt = ST_WFIN;
            ST_WFIN:    state_nxt = (mode_q == MODE_WR_ONLY) ? ST_IDLE : ST_RSTART;
            ST_RSTART:  state_nxt = dtype_q ? ST_RSEED : ST_RADDR;
            ST_RSEED:   if (seed_last) state_nxt = ST_RADDR;
            ST_RADDR:   state_nxt = ST_RCMD;
            ST_RCMD: begin
                if (sched_rdy_i) begin
                    if (wb_mode)        state_nxt = ST_RWBADDR;
                    else if (addr_last) state_nxt = ST_RDRAIN;
                    else                state_nxt = ST_RADDR;
                end
            end
            ST_RWBADDR: state_nxt = ST_RWBCMD;
            ST_RWBCMD: begin
                if (sched_rdy_i) state_nxt = addr_last ? ST_RDRAIN : ST_RADDR;
            end
            ST_RDRAIN:  if (sched_rdy_i) state_nxt = ST_RFIN;
            ST_RFIN:    state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        cmd_vld_o = 1'b0;
        cmd_wr_o  = 1'b0;
        seed_run  = 1'b0;
        addr_step = 1'b0;
        pass_init = start_acc;
        unique case (state_q)
            ST_WSEED, ST_RSEED: seed_run  = 1'b1;
            ST_WADDR, ST_RADDR: addr_step = 1'b1;
            ST_WCMD, ST_RWBCMD: begin
                cmd_vld_o = 1'b1;
                cmd_wr_o  = 1'b1;
            end
            ST_RCMD:            cmd_vld_o = 1'b1;
            ST_RSTART:          pass_init = 1'b1;
            default:            ;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;

    mbist_pat_gen #(.NUM_PAT(NUM_PAT)) u_pat (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .fill_fixed_i (fill_fixed),
        .init_i       (pass_init),
        .run_i        (seed_run),
        .seed_i       (seed_src),
        .pat_o        (pat_o),
        .last_o       (seed_last)
    );

    mbist_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (pass_init),
        .step_i    (addr_step),
        .lo_i      (lo_q),
        .hi_i      (hi_q),
        .addr_o    (cmd_addr_o),
        .last_o    (addr_last)
    );

    mbist_cmp #(.NUM_PAT(NUM_PAT), .ADDR_W(ADDR_W)) u_cmp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (start_acc),
        .chk_i  (rd_vld_i),
        .addr_i (rd_addr_i),
        .data_i (rd_data_i),
        .pat_i  (pat_o),
        .err_o  (err_o)
    );

    // R5: an unaccepted command is held unchanged
    p_cmd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_vld_o && !sched_rdy_i) |=> (cmd_vld_o && $stable(cmd_addr_o) && $stable(cmd_wr_o)));

    // R6: an address-preparation cycle follows every accepted command
    p_gap_after_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_vld_o && sched_rdy_i) |=> !cmd_vld_o);

    // R10: the end pulse comes while idle and lasts one cycle
    p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);
    p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R2: an accepted start makes the block busy
    p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_acc |=> busy_o);

endmodule

// File: tb/mbist_seq_tb_top.sv
`timescale 1ns/1ps
module mbist_seq_tb_top;

    localparam int unsigned AW = 8;
    localparam int unsigned NP = 5;
    localparam logic [31:0] POLY = 32'h04C11DB7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          dtype = 1'b0;
    logic [31:0]   seed = 32'h0;
    logic [AW-1:0] lo = '0;
    logic [AW-1:0] hi = '0;
    logic          rdy = 1'b0;
    logic          rvld = 1'b0;
    logic [AW-1:0] raddr = '0;
    logic [31:0]   rdata = 32'h0;
    logic          cvld, cwr, busy, done, err;
    logic [AW-1:0] caddr;
    logic [NP*32-1:0] pat;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mbist_seq #(.ADDR_W(AW), .NUM_PAT(NP)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
        .dtype_i(dtype), .seed_i(seed), .addr_lo_i(lo), .addr_hi_i(hi),
        .sched_rdy_i(rdy), .rd_vld_i(rvld), .rd_addr_i(raddr), .rd_data_i(rdata),
        .cmd_vld_o(cvld), .cmd_wr_o(cwr), .cmd_addr_o(caddr), .pat_o(pat),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_word(input logic [31:0] w);
        logic [31:0] r;
        r = w << 1;
        if (w[31]) r = r ^ POLY;
        return r;
    endfunction

    function automatic logic [31:0] exp_word(input logic dt, input logic [31:0] sd, input int k);
        logic [31:0] w;
        w = sd;
        if (!dt) return sd;
        for (int i = 0; i <= k; i++) w = next_word(w);
        return w;
    endfunction

    task automatic run_test(input string name, input logic [1:0] md, input logic dt,
                            input logic [31:0] sd, input logic [AW-1:0] l, input logic [AW-1:0] h,
                            input logic [31:0] mask, input int exp_first, input int exp_rdgap,
                            output int done_at);
        bit          e_wr [256];
        int          e_ad [256];
        bit          g_wr [256];
        int          g_ad [256];
        int          ne = 0, ng = 0;
        int          first_seen = -1, last_wr_acc = -1, first_rd = -1;
        int          hold_bad = 0, gap_bad = 0, busy_bad = 0, done_cnt = 0, done_bad = 0;
        bit          p_vld = 0, p_rdy = 0, p_wr = 0;
        logic [AW-1:0] p_ad = '0;
        int          n = 0;
        done_at = -1;
        if (md != 2'd3)
            for (int a = int'(l); a <= int'(h); a++) begin e_wr[ne] = 1; e_ad[ne] = a; ne++; end
        if (md != 2'd0)
            for (int a = int'(l); a <= int'(h); a++) begin
                e_wr[ne] = 0; e_ad[ne] = a; ne++;
                if (md[1]) begin e_wr[ne] = 1; e_ad[ne] = a; ne++; end
            end
        @(negedge clk);
        mode = md; dtype = dt; seed = sd; lo = l; hi = h; start = 1'b1; rdy = mask[0];
        @(negedge clk);
        start = 1'b0;
        mode = ~md; dtype = ~dt; seed = ~sd; lo = 8'd0; hi = 8'd255;   // R2: no effect after capture
        while (n < 600) begin
            rdy = mask[n % 32];
            if (n == 0) begin
                chk(err == 1'b0, {name, " R11 err cleared by start"}, err, 0);
                chk(busy == 1'b1, {name, " R2 busy after start"}, busy, 1);
            end
            if (n == 3) start = 1'b1;                  // R2: start while busy
            if (n == 4) start = 1'b0;
            if (p_vld && !p_rdy && !(cvld && caddr == p_ad && cwr == p_wr)) hold_bad++;
            if (p_vld && p_rdy && cvld) gap_bad++;
            if (cvld && first_seen < 0) first_seen = n;
            if (cvld && !cwr && first_rd < 0) first_rd = n;
            if (cvld && rdy) begin
                if (ng < 256) begin g_wr[ng] = cwr; g_ad[ng] = int'(caddr); end
                ng++;
                if (cwr && first_rd < 0) last_wr_acc = n;
            end
            if (done) begin
                done_cnt++;
                if (busy) done_bad++;
                if (done_at < 0) done_at = n;
            end
            if (done_at < 0 && !busy) busy_bad++;
            if (done_at >= 0 && n == done_at + 1) begin
                if (done) done_bad++;
                break;
            end
            p_vld = cvld; p_rdy = rdy; p_wr = cwr; p_ad = caddr;
            @(negedge clk);
            n++;
        end
        rdy = 1'b0;
        chk(ng == ne, {name, " R3 command count"}, ng, ne);
        for (int i = 0; i < ne && i < ng; i++) begin
            chk(g_wr[i] == e_wr[i], {name, " R3 command type order"}, g_wr[i], e_wr[i]);
            chk(g_ad[i] == e_ad[i], {name, " R4 command address"}, g_ad[i], e_ad[i]);
        end
        chk(hold_bad == 0, {name, " R5 held command"}, hold_bad, 0);
        chk(gap_bad == 0, {name, " R6 gap after accept"}, gap_bad, 0);
        chk(busy_bad == 0, {name, " R9 busy until finish"}, busy_bad, 0);
        chk(done_cnt == 1 && done_bad == 0, {name, " R10 done pulse"}, done_cnt, 1);
        if (exp_first >= 0)
            chk(first_seen == exp_first, {name, " R7 first command latency"}, first_seen, exp_first);
        if (exp_rdgap >= 0)
            chk(first_rd - last_wr_acc == exp_rdgap, {name, " R8 read pass latency"},
                first_rd - last_wr_acc, exp_rdgap);
        for (int k = 0; k < int'(NP); k++)
            chk(pat[k*32 +: 32] == exp_word(dt, sd, k), {name, " R7 R12 pattern word"},
                pat[k*32 +: 32], exp_word(dt, sd, k));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cvld == 0, "R1 reset cmd_vld", cvld, 0);
        chk(busy == 0, "R1 reset busy", busy, 0);
        chk(done == 0, "R1 reset done", done, 0);
        chk(err == 0, "R1 reset err", err, 0);
    endtask

    task automatic t_compare(input logic [31:0] sd);
        @(negedge clk);
        rvld = 1; raddr = 8'd7; rdata = exp_word(1, sd, 2);     // 7 mod 5 = 2
        @(negedge clk);
        chk(err == 0, "R11 matching read at addr 7", err, 0);
        raddr = 8'd14; rdata = exp_word(1, sd, 4);
        @(negedge clk);
        chk(err == 0, "R11 matching read at addr 14", err, 0);
        raddr = 8'd13; rdata = exp_word(1, sd, 3) ^ 32'h1;
        @(negedge clk);
        rvld = 0;
        chk(err == 1, "R11 mismatch sets err", err, 1);
        @(negedge clk);
        @(negedge clk);
        chk(err == 1, "R11 err sticky", err, 1);
    endtask

    task automatic t_drain();
        int d;
        // WCMD at n=1 accepted, drain stalled for n=2..5, ready at n=6
        run_test("drain", 2'd0, 1'b0, 32'h0BAD_F00D, 8'd7, 8'd7, 32'hFFFF_FFC3, 1, -1, d);
        chk(d == 8, "R9 drain holds until ready", d, 8);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d;
        #35 rst_n = 1'b1;
        t_reset();
        run_test("wr_only", 2'd0, 1'b0, 32'hA5A5_0F0F, 8'd3, 8'd6, 32'hFFFF_FFFF, 1, -1, d);
        run_test("wr_rd_crc", 2'd1, 1'b1, 32'h1234_5678, 8'd10, 8'd12, 32'hFFFF_FFFF, 6, 10, d);
        run_test("wr_rd_top", 2'd1, 1'b0, 32'h8000_0001, 8'd250, 8'd255, 32'hFFFF_FFFF, 1, 5, d);
        run_test("wr_rdwb_one", 2'd2, 1'b1, 32'hDEAD_BEEF, 8'd5, 8'd5, 32'h6DB6_DB6D, 6, -1, d);
        run_test("rdwb_only", 2'd3, 1'b1, 32'hCAFE_0001, 8'd0, 8'd2, 32'hA5A5_A5A5, 7, -1, d);
        t_compare(32'hCAFE_0001);
        t_drain();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule